// File: doc/BRIEF.md
# Paired-Channel PWM Controller

This block generates an even number of pulse-width-modulated outputs from one system clock. It is configured through a plain 32-bit register port. Channels are grouped two by two. Each pair shares one setting that chooses between two tick-enable sources and divides the chosen tick rate by a power of two. Each channel then divides that pair tick further by its own linear prescaler. It counts the result through a period of programmable length and drives its pin at the active level for a programmable number of those ticks.

A channel produces a waveform only when both its enable bit and its gating bit are set. A disabled channel releases its pin, with its output-enable low. Any write that changes a channel's timing abandons the period in progress: the counters concerned restart from zero in the next cycle. A per-channel bypass bit routes the pair's divided tick straight to the pin, which gives a fast square-like reference.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: After reset every register reads zero, and every output-enable and output value is low.
- R2: Registers read back through the port. The pair setting at 0x20 + 4*p holds the source field in bits 8:7 and the exponent in bits 3:0. The gate register at 0x40 holds the gating bit for channel n at bit n and the bypass bit at bit n+16. The enable register at 0x80 has one bit per channel. The channel control register at 0x100 + 0x20*n holds the polarity in bit 8 and the prescaler in bits 7:0. The channel period register at 0x104 + 0x20*n holds the length field E in bits 31:16 and the active field A in bits 15:0. Unused bits read zero. An unmapped offset reads zero, and a write to it changes nothing.
- R3: Channels 2p and 2p+1 both use pair setting p. A source field of 0 selects the oscillator tick, and any other value selects the bus tick.
- R4: The pair tick fires once every 2^M selected ticks, with M taken from bits 3:0 and values above 8 acting as 8. The pair divider stays at zero while neither channel of the pair runs.
- R5: The channel counter advances once every K+1 pair ticks, with K taken from control bits 7:0.
- R6: The channel counter steps 0, 1, …, E and then wraps to 0, so one period lasts E+1 prescaled ticks. The pin is active while the counter is below A.
- R7: With A = 0 the pin never goes active. With A ≥ E+1 the pin stays active for the whole period.
- R8: With polarity bit 1 the active level is high. With polarity bit 0 it is low.
- R9: A channel whose enable bit is clear has its output-enable low and its output value low.
- R10: An enabled channel whose gating bit is clear has its output-enable high. Its pin holds the inactive level and its counters stay at zero.
- R11: With its bypass bit set, an enabled channel's pin equals its pair's divided tick.
- R12: A write to a channel's control or period register, or to its pair setting, restarts that channel's prescaler and period counter from zero. A write to the pair setting also restarts the pair divider. In the cycle after the write the channel is at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Oscillator-rate tick enable (source 0) |
| bus_tick | input | 1 | Bus-rate tick enable (any other source) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NCH | Output value per channel |
| pwm_oe | output | NCH | Output-enable per channel, low means high-impedance |

## Verification
A wrong internal count shows on the pin within one period. A prescaler or divider off by one stretches each step of the waveform, and the scoreboard sees this as an edge one or more cycles early or late. The check compares every cycle against a closed-form model of the three cascaded counters, so a miss shows at the first cycle where model and pin differ. A missing restart on write shows in the first cycle after the write, because the pin then keeps the old phase instead of beginning at count zero. A source or pairing fault shows as a frozen pin when the channel should be ticking from the other source.

// File: rtl/pwm_pair_pkg.sv
// Shared constants and configuration types for the paired PWM controller.
// Field widths are fixed by the register format; channel count lives on the top.
package pwm_pair_pkg;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 8;
    localparam int EXP_W    = 4;
    localparam int SRC_W    = 2;
    localparam int MAX_EXP  = 8;
    localparam int DIV_W    = MAX_EXP + 1;

    localparam int CFG_BASE = 'h20;
    localparam int CFG_STEP = 4;
    localparam int GATE_OFS = 'h40;
    localparam int BYP_LSB  = 16;
    localparam int EN_OFS   = 'h80;
    localparam int CH_BASE  = 'h100;
    localparam int CH_STEP  = 'h20;
    localparam int PER_OFS  = 4;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [EXP_W-1:0] expo;
    } pair_cfg_t;

    typedef struct packed {
        logic             en;
        logic             gate;
        logic             byp;
        logic             act_high;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] act;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_pair_regs.sv
// Register file: decodes the 32-bit port, holds all settings, serves readback
// and emits restart strobes. Assumes NCH is even and at most 16.
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    localparam int NPAIR = NCH / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output pair_cfg_t [NPAIR-1:0]   pr_cfg,
    output chan_cfg_t [NCH-1:0]     ch_cfg,
    output logic [NPAIR-1:0]        pr_wr,
    output logic [NCH-1:0]          ch_wr
);
    function automatic logic [ADDR_W-1:0] cfg_addr(input int p);
        return ADDR_W'(CFG_BASE + p * CFG_STEP);
    endfunction
    function automatic logic [ADDR_W-1:0] ctl_addr(input int n);
        return ADDR_W'(CH_BASE + n * CH_STEP);
    endfunction
    function automatic logic [ADDR_W-1:0] per_addr(input int n);
        return ADDR_W'(CH_BASE + n * CH_STEP + PER_OFS);
    endfunction

    localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_OFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

    pair_cfg_t [NPAIR-1:0]           pr_q;
    logic [NCH-1:0]                  gate_q, byp_q, en_q, pol_q;
    logic [NCH-1:0][PRE_W-1:0]       presc_q;
    logic [NCH-1:0][CNT_W-1:0]       len_q, act_q;

    // Write strobes that restart counters
    always_comb begin
        for (int p = 0; p < NPAIR; p++)
            pr_wr[p] = reg_wr && (reg_addr == cfg_addr(p));
        for (int n = 0; n < NCH; n++)
            ch_wr[n] = reg_wr && ((reg_addr == ctl_addr(n)) || (reg_addr == per_addr(n)));
    end

    // Register storage updated by port writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q    <= '0;
            gate_q  <= '0;
            byp_q   <= '0;
            en_q    <= '0;
            pol_q   <= '0;
            presc_q <= '0;
            len_q   <= '0;
            act_q   <= '0;
        end else if (reg_wr) begin
            for (int p = 0; p < NPAIR; p++) begin
                if (reg_addr == cfg_addr(p)) begin
                    pr_q[p].src  <= reg_wdata[8:7];
                    pr_q[p].expo <= reg_wdata[3:0];
                end
            end
            if (reg_addr == GATE_A) begin
                gate_q <= reg_wdata[NCH-1:0];
                byp_q  <= reg_wdata[BYP_LSB +: NCH];
            end
            if (reg_addr == EN_A)
                en_q <= reg_wdata[NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (reg_addr == ctl_addr(n)) begin
                    pol_q[n]   <= reg_wdata[8];
                    presc_q[n] <= reg_wdata[PRE_W-1:0];
                end
                if (reg_addr == per_addr(n)) begin
                    len_q[n] <= reg_wdata[31:16];
                    act_q[n] <= reg_wdata[15:0];
                end
            end
        end
    end

    // Pack per-channel settings for the datapath
    always_comb begin
        pr_cfg = pr_q;
        for (int n = 0; n < NCH; n++) begin
            ch_cfg[n].en       = en_q[n];
            ch_cfg[n].gate     = gate_q[n];
            ch_cfg[n].byp      = byp_q[n];
            ch_cfg[n].act_high = pol_q[n];
            ch_cfg[n].presc    = presc_q[n];
            ch_cfg[n].len      = len_q[n];
            ch_cfg[n].act      = act_q[n];
        end
    end

    // Readback multiplexer, zero for unmapped offsets
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPAIR; p++) begin
            if (reg_addr == cfg_addr(p)) begin
                reg_rdata[8:7] = pr_q[p].src;
                reg_rdata[3:0] = pr_q[p].expo;
            end
        end
        if (reg_addr == GATE_A) begin
            reg_rdata[NCH-1:0]         = gate_q;
            reg_rdata[BYP_LSB +: NCH]  = byp_q;
        end
        if (reg_addr == EN_A)
            reg_rdata[NCH-1:0] = en_q;
        for (int n = 0; n < NCH; n++) begin
            if (reg_addr == ctl_addr(n)) begin
                reg_rdata[8]         = pol_q[n];
                reg_rdata[PRE_W-1:0] = presc_q[n];
            end
            if (reg_addr == per_addr(n))
                reg_rdata = {len_q[n], act_q[n]};
        end
    end
endmodule

// File: rtl/pwm_pair_div.sv
// Pair divider: picks the tick source and passes one of every 2^M ticks.
// Assumes the exponent saturates at MAX_EXP; counter held at zero when idle.
module pwm_pair_div
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       bus_tick,
    input  pair_cfg_t  cfg,
    input  logic       clr,
    input  logic       run_any,
    output logic       div_tick
);
    logic [DIV_W-1:0] cnt;
    logic [EXP_W-1:0] m_eff;
    logic [DIV_W-1:0] limit;
    logic             src_tick;

    // Source choice, saturated exponent and terminal count
    always_comb begin
        src_tick = (cfg.src == '0) ? osc_tick : bus_tick;
        m_eff    = (cfg.expo > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg.expo;
        limit    = (DIV_W'(1) << m_eff) - DIV_W'(1);
        div_tick = run_any && src_tick && (cnt == limit);
    end

    // Power-of-two tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run_any)
            cnt <= '0;
        else if (src_tick)
            cnt <= (cnt == limit) ? '0 : cnt + DIV_W'(1);
    end
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: linear prescaler, period counter and pin logic.
// Assumes div_tick is the pair tick; clr restarts both counters.
module pwm_chan
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg,
    input  logic              div_tick,
    input  logic              clr,
    output logic              pin,
    output logic              oe,
    output logic [PRE_W-1:0]  pre_cnt,
    output logic [CNT_W-1:0]  per_cnt
);
    logic run, pre_tick, active;

    // Run qualifier, prescaled tick and compare
    always_comb begin
        run      = cfg.en && cfg.gate;
        pre_tick = run && div_tick && (pre_cnt == cfg.presc);
        active   = per_cnt < cfg.act;
    end

    // Linear prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            pre_cnt <= '0;
        else if (div_tick)
            pre_cnt <= (pre_cnt == cfg.presc) ? '0 : pre_cnt + PRE_W'(1);
    end

    // Period counter wrapping after the length value
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            per_cnt <= '0;
        else if (pre_tick)
            per_cnt <= (per_cnt >= cfg.len) ? '0 : per_cnt + CNT_W'(1);
    end

    // Pin value and output-enable
    always_comb begin
        oe = cfg.en;
        if (!cfg.en)
            pin = 1'b0;
        else if (cfg.byp)
            pin = div_tick;
        else if (run)
            pin = cfg.act_high ? active : !active;
        else
            pin = !cfg.act_high;
    end
endmodule

// File: rtl/pwm_pair_ctrl.sv
// Top: register file, one divider per channel pair, one channel per output.
// Assumes NCH is even and at most 16; single clock domain.
module pwm_pair_ctrl
    import pwm_pair_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_oe
);
    localparam int NPAIR = NCH / 2;

    pair_cfg_t [NPAIR-1:0]        pr_cfg;
    chan_cfg_t [NCH-1:0]          ch_cfg;
    logic [NPAIR-1:0]             pr_wr;
    logic [NCH-1:0]               ch_wr;
    logic [NPAIR-1:0]             div_tick;
    logic [NCH-1:0][PRE_W-1:0]    pre_cnt;
    logic [NCH-1:0][CNT_W-1:0]    per_cnt;

    pwm_pair_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pr_cfg    (pr_cfg),
        .ch_cfg    (ch_cfg),
        .pr_wr     (pr_wr),
        .ch_wr     (ch_wr)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic run_any;
        // Pair runs while either member is enabled and gated
        always_comb run_any = (ch_cfg[2*p].en && ch_cfg[2*p].gate)
                           || (ch_cfg[2*p+1].en && ch_cfg[2*p+1].gate);

        pwm_pair_div u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .osc_tick (osc_tick),
            .bus_tick (bus_tick),
            .cfg      (pr_cfg[p]),
            .clr      (pr_wr[p]),
            .run_any  (run_any),
            .div_tick (div_tick[p])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic restart;
        // Own register write or shared pair write restarts the channel
        always_comb restart = ch_wr[n] || pr_wr[n/2];

        pwm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (ch_cfg[n]),
            .div_tick (div_tick[n/2]),
            .clr      (restart),
            .pin      (pwm_out[n]),
            .oe       (pwm_oe[n]),
            .pre_cnt  (pre_cnt[n]),
            .per_cnt  (per_cnt[n])
        );
    end
endmodule

// File: rtl/pwm_pair_chk.sv
// Assertion checker bound into the top; observes ports and counter state.
module pwm_pair_chk
    import pwm_pair_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    localparam int NPAIR = NCH / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_tick,
    input  logic                     bus_tick,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [NCH-1:0]           pwm_out,
    input  logic [NCH-1:0]           pwm_oe,
    input  pair_cfg_t [NPAIR-1:0]    pr_cfg,
    input  chan_cfg_t [NCH-1:0]      ch_cfg,
    input  logic [NPAIR-1:0]         div_tick,
    input  logic [NCH-1:0][PRE_W-1:0] pre_cnt,
    input  logic [NCH-1:0][CNT_W-1:0] per_cnt
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_pc
        // R3
        div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            div_tick[p] |-> ((pr_cfg[p].src == '0) ? osc_tick : bus_tick));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_cc
        // R6
        cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            per_cnt[n] <= ch_cfg[n].len);
        // R5
        pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pre_cnt[n] <= ch_cfg[n].presc);
        // R9
        hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_oe[n] |-> !pwm_out[n]);
        // R10
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(ch_cfg[n].en && ch_cfg[n].gate) |=> (per_cnt[n] == '0 && pre_cnt[n] == '0));
        // R12
        restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(CH_BASE + n * CH_STEP + PER_OFS))
            |=> (per_cnt[n] == '0 && pre_cnt[n] == '0));
        // R7
        full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_cfg[n].en && ch_cfg[n].gate && !ch_cfg[n].byp && ch_cfg[n].act > ch_cfg[n].len)
            |-> (pwm_out[n] == ch_cfg[n].act_high));
    end
endmodule

bind pwm_pair_ctrl pwm_pair_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .bus_tick (bus_tick),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .pwm_out  (pwm_out),
    .pwm_oe   (pwm_oe),
    .pr_cfg   (pr_cfg),
    .ch_cfg   (ch_cfg),
    .div_tick (div_tick),
    .pre_cnt  (pre_cnt),
    .per_cnt  (per_cnt)
);

// File: tb/pwm_pair_ctrl_tb.sv
// Scoreboard bench: driver tasks queue expected pin states, a monitor compares.
module pwm_pair_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic        bus_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] pwm_out, pwm_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    ch;
        logic  pin;
        logic  oe;
        int    k;
        string tag;
    } item_t;
    item_t sb[$];
    item_t it;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare one queued item per cycle, just after the falling edge
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            chk(pwm_out[it.ch] === it.pin && pwm_oe[it.ch] === it.oe,
                $sformatf("%s ch%0d k=%0d {oe,pin}", it.tag, it.ch, it.k),
                {30'd0, pwm_oe[it.ch], pwm_out[it.ch]}, {30'd0, it.oe, it.pin});
        end
    end

    function automatic int cfg_a(int ch); return 'h20 + (ch / 2) * 4; endfunction
    function automatic int ctl_a(int ch); return 'h100 + ch * 'h20; endfunction
    function automatic int per_a(int ch); return 'h104 + ch * 'h20; endfunction

    // Expected pin from the requirements (R4..R8, R10, R11)
    function automatic logic model(int m, int k_pre, int e, int a, bit pol, bit byp,
                                   bit run, bit tk, int k);
        int d, c, kk;
        if (byp) begin
            d = 1 << ((m > 8) ? 8 : m);
            return tk && ((k % d) == d - 1);
        end
        if (!run) return !pol;
        d  = 1 << ((m > 8) ? 8 : m);
        kk = tk ? k : 0;
        c  = ((kk / d) / (k_pre + 1)) % (e + 1);
        return pol ? (c < a) : !(c < a);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 12'(a);
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic setup(int ch, int src, int m, int k_pre, int e, int a, bit pol);
        wr(cfg_a(ch), 32'((src << 7) | m));
        wr(ctl_a(ch), 32'((int'(pol) << 8) | k_pre));
        wr(per_a(ch), 32'((e << 16) | a));
    endtask

    // Driver: queue expected pin values for the next n cycles, then wait them out
    task automatic expect_run(int ch, int m, int k_pre, int e, int a, bit pol, bit byp,
                              bit run, bit tk, int n, string tag);
        for (int k = 0; k < n; k++) begin
            item_t x;
            x.ch = ch; x.oe = 1'b1; x.k = k; x.tag = tag;
            x.pin = model(m, k_pre, e, a, pol, byp, run, tk, k);
            sb.push_back(x);
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_off(int ch, int n, string tag);
        for (int k = 0; k < n; k++) begin
            item_t x;
            x.ch = ch; x.oe = 1'b0; x.pin = 1'b0; x.k = k; x.tag = tag;
            sb.push_back(x);
        end
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd('h20, 0, "R1 pair cfg 0");
        rd('h24, 0, "R1 pair cfg 1");
        rd('h40, 0, "R1 gate");
        rd('h80, 0, "R1 enable");
        rd('h100, 0, "R1 ctl0");
        rd('h164, 0, "R1 per3");
        chk(pwm_oe === '0 && pwm_out === '0, "R1 outputs", {24'd0, pwm_oe, pwm_out}, 0);

        // R2: readback, unused bits, unmapped offsets
        wr('h20, 32'hFFFF_FFFF);  rd('h20, 32'h0000_018F, "R2 pair cfg fields");
        wr('h120, 32'hFFFF_FFFF); rd('h120, 32'h0000_01FF, "R2 ctl1 fields");
        wr('h164, 32'h1234_5678); rd('h164, 32'h1234_5678, "R2 per3 fields");
        wr('h40, 32'hFFFF_FFFF);  rd('h40, 32'h000F_000F, "R2 gate fields");
        wr('h84, 32'hFFFF_FFFF);  rd('h84, 0, "R2 unmapped read");
        rd('h164, 32'h1234_5678, "R2 unmapped write ignored");
        wr('h20, 0); wr('h120, 0); wr('h164, 0);
        wr('h40, 32'h0000_000F);

        // R6: basic period and duty
        setup(0, 0, 0, 0, 4, 2, 1'b1);
        wr('h80, 1);
        expect_run(0, 0, 0, 4, 2, 1, 0, 1, 1, 15, "R6 E4 A2");
        wr('h80, 0);

        // R7: zero and full duty
        setup(0, 0, 0, 0, 4, 0, 1'b1); wr('h80, 1);
        expect_run(0, 0, 0, 4, 0, 1, 0, 1, 1, 10, "R7 A0");
        wr('h80, 0);
        setup(0, 0, 0, 0, 4, 5, 1'b1); wr('h80, 1);
        expect_run(0, 0, 0, 4, 5, 1, 0, 1, 1, 10, "R7 A=E+1");
        wr('h80, 0);
        setup(0, 0, 0, 0, 4, 'hFFFF, 1'b1); wr('h80, 1);
        expect_run(0, 0, 0, 4, 'hFFFF, 1, 0, 1, 1, 10, "R7 A max");
        wr('h80, 0);

        // R8: active-low polarity
        setup(0, 0, 0, 0, 4, 2, 1'b0); wr('h80, 1);
        expect_run(0, 0, 0, 4, 2, 0, 0, 1, 1, 10, "R8 low active");
        wr('h80, 0);

        // R5: prescaler
        setup(0, 0, 0, 2, 3, 1, 1'b1); wr('h80, 1);
        expect_run(0, 0, 2, 3, 1, 1, 0, 1, 1, 30, "R5 K2");
        wr('h80, 0);

        // R4: power-of-two divider and saturation of M
        setup(0, 0, 2, 1, 2, 1, 1'b1); wr('h80, 1);
        expect_run(0, 2, 1, 2, 1, 1, 0, 1, 1, 40, "R4 M2");
        wr('h80, 0);
        setup(0, 0, 15, 0, 1, 1, 1'b1); wr('h80, 1);
        expect_run(0, 15, 0, 1, 1, 1, 0, 1, 1, 600, "R4 M15 as 8");
        wr('h80, 0);
        wr('h20, 0);

        // R3: pair sharing and source select (channel 1 uses pair 0 setting)
        osc_tick = 1'b0; bus_tick = 1'b1;
        setup(1, 2, 1, 0, 2, 1, 1'b1); wr('h80, 2);
        expect_run(1, 1, 0, 2, 1, 1, 0, 1, 1, 20, "R3 bus source");
        wr('h80, 0);
        setup(1, 0, 1, 0, 2, 1, 1'b1); wr('h80, 2);
        expect_run(1, 1, 0, 2, 1, 1, 0, 1, 0, 10, "R3 osc source idle");
        wr('h80, 0);
        osc_tick = 1'b1; bus_tick = 1'b0;
        setup(2, 0, 0, 0, 2, 1, 1'b1); wr('h80, 4);
        expect_run(2, 0, 0, 2, 1, 1, 0, 1, 1, 9, "R3 pair1 own setting");
        wr('h80, 0);
        wr('h20, 0);

        // R9: disabled channel released
        setup(0, 0, 0, 0, 4, 2, 1'b1);
        expect_off(0, 5, "R9 disabled");

        // R10: enabled but not gated
        wr('h40, 32'h0000_000E); wr('h80, 1);
        expect_run(0, 0, 0, 4, 2, 1, 0, 0, 1, 8, "R10 ungated");
        wr('h80, 0);

        // R11: bypass follows pair tick
        wr('h40, 32'h0001_000F);
        setup(0, 0, 1, 0, 4, 2, 1'b1); wr('h80, 1);
        expect_run(0, 1, 0, 4, 2, 1, 1, 1, 1, 12, "R11 bypass");
        wr('h80, 0);
        wr('h40, 32'h0000_000F);

        // R12: writes restart the running channel
        setup(0, 0, 0, 0, 4, 2, 1'b1); wr('h80, 1);
        expect_run(0, 0, 0, 4, 2, 1, 0, 1, 1, 7, "R12 before write");
        wr(per_a(0), 32'h0004_0002);
        expect_run(0, 0, 0, 4, 2, 1, 0, 1, 1, 8, "R12 after period write");
        wr(cfg_a(0), 0);
        expect_run(0, 0, 0, 4, 2, 1, 0, 1, 1, 8, "R12 after pair write");
        wr('h80, 0);

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule